// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is the receive and read side of a serial memory that sits on a two-wire I2C bus as a target. It samples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It matches the target address byte and keeps an 11-bit read pointer over a 2048-byte read-only array. The array is filled with a fixed pattern and is read one clock after the address is presented.

A master sets the pointer with a dummy write. It sends the target address with the direction bit cleared, then a word-address byte, then a repeated START and the target address with the direction bit set. The block then sends the addressed byte. Each master ACK after a data byte fetches the next location, and the pointer wraps from the top of the array back to zero. A read that is not preceded by a dummy write starts at the current pointer.

An external hold input blocks every acknowledge while it is high. SDA is modelled only as an output-enable: when it is high, the line is pulled low.

Top module: `i2c_rd_target`

## Requirements
- R1: After reset, sdaOe is low and the read pointer is 0, so a read that has no dummy write returns location 0 first.
- R2: After a START, the block shifts in eight bits MSB first. If bits [7:4] of that byte equal 4'b1010, it pulls SDA low for the whole ninth SCL high period. Any other value gets no acknowledge, and the block ignores the bus until the next START or STOP, so reads return 8'hFF.
- R3: In the target byte, bit 0 is the direction (0 = write) and bits [3:1] are the upper three address bits. After a write-direction target byte, the next byte is the low eight address bits. That byte is acknowledged and loads the pointer with {bits[3:1], byte}.
- R4: After it acknowledges a read-direction target byte, the block shifts out the byte at the pointer MSB first, one bit per SCL clock. Location A holds A[7:0] XOR {A[10:8], 5'b10101}.
- R5: A master ACK (SDA low on the ninth clock) after a data byte makes the block send the byte at the next address. Address 2047 is followed by address 0.
- R6: A master NACK after a data byte makes the block release SDA and stay silent until a START or STOP.
- R7: A read without a dummy write starts one location past the last byte sent.
- R8: While holdIn is high, no target byte and no word-address byte is acknowledged. A master ACK seen while holdIn is high ends the read instead of fetching another byte.
- R9: A START or STOP inside a byte abandons that byte. A START restarts address matching, and a STOP returns to idle. An abandoned word-address byte leaves the pointer unchanged.
- R10: The block changes sdaOe only while SCL is low. The one exception is the cycle that follows a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired-AND) |
| holdIn | input | 1 | High blocks every acknowledge |
| sdaOe | output | 1 | High pulls SDA low |

## Verification
A corrupted state register or bit counter moves the ninth-clock acknowledge or shifts the data by a bit. Either error shows as a missing ACK or a wrong byte at the master within one byte time. A pointer that loads or steps wrongly shows up in the very next data byte, and the bench's own pointer model catches it. This holds at the wrap from 2047 to 0, after an abandoned word byte, and in current-address reads. Every change of sdaOe is also compared against the SCL level the master drives, so an output that moves while SCL is high is reported at once.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXDEV,
    ST_ACKDEV,
    ST_RXWORD,
    ST_ACKWORD,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic shiftRx;
    logic latchBlk;
    logic loadPtr;
    logic loadTx;
    logic shiftTx;
  } ctlT;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sclLvl;
    logic sdaLvl;
  } busEvT;

endpackage

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] memArr [DEPTH];

  function automatic logic [7:0] fillByte(input int unsigned a);
    logic [7:0] hiPart;
    hiPart = 8'((a >> 8) << 5);
    return 8'(a) ^ hiPart ^ 8'h15;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) memArr[i] = fillByte(i);
  end

  always_ff @(posedge clk) q <= memArr[addr];

endmodule

// File: rtl/i2c_rd_dp.sv
module i2c_rd_dp
  import i2c_rd_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlT               ctl,
  input  logic [7:0]        memQ,
  output busEvT             ev,
  output logic [3:0]        rxHi,
  output logic              rwBit,
  output logic [3:0]        bitCnt,
  output logic              txBit,
  output logic [ADDR_W-1:0] ptr
);
  localparam int BLK_W = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic                   sclPrev, sdaPrev;
  logic [7:0]             rxByte, txShift;
  logic [BLK_W-1:0]       blkReg;
  logic                   sclLvl, sdaLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl = sclSync[SYNC_STAGES-1];
  assign sdaLvl = sdaSync[SYNC_STAGES-1];

  always_comb begin
    ev.sclLvl  = sclLvl;
    ev.sdaLvl  = sdaLvl;
    ev.sclRise = sclLvl & ~sclPrev;
    ev.sclFall = ~sclLvl & sclPrev;
    ev.startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
    ev.stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte  <= '0;
      txShift <= '0;
      bitCnt  <= '0;
      blkReg  <= '0;
      rwBit   <= 1'b0;
      ptr     <= '0;
    end else begin
      if (ctl.shiftRx) rxByte <= {rxByte[6:0], sdaLvl};
      if (ctl.clrCnt) bitCnt <= '0;
      else if (ctl.shiftRx || ctl.shiftTx) bitCnt <= bitCnt + 4'd1;
      if (ctl.latchBlk) begin
        blkReg <= rxByte[BLK_W:1];
        rwBit  <= rxByte[0];
      end
      if (ctl.loadTx) txShift <= memQ;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b0};
      if (ctl.loadPtr) ptr <= {blkReg, rxByte};
      else if (ctl.loadTx) ptr <= ptr + 1'b1;
    end
  end

  assign rxHi  = rxByte[7:4];
  assign txBit = txShift[7];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ptr != $past(ptr)) |-> ($past(ctl.loadPtr) || ptr == ADDR_W'($past(ptr) + 1'b1))); // R5

endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdIn,
  input  busEvT      ev,
  input  logic [3:0] rxHi,
  input  logic       rwBit,
  input  logic [3:0] bitCnt,
  input  logic       txBit,
  output ctlT        ctl,
  output logic       sdaOe
);
  stateT state, nxt;
  logic  mAck;
  logic  ackPhase;

  always_comb begin
    ctl = '0;
    nxt = state;
    if (ev.stopEv) begin
      nxt = ST_IDLE;
    end else if (ev.startEv) begin
      nxt = ST_RXDEV;
      ctl.clrCnt = 1'b1;
    end else begin
      case (state)
        ST_RXDEV, ST_RXWORD: begin
          if (ev.sclRise && bitCnt < 4'd8) begin
            ctl.shiftRx = 1'b1;
          end else if (ev.sclFall && bitCnt == 4'd8) begin
            if (holdIn) nxt = ST_WAIT;
            else if (state == ST_RXWORD) begin
              nxt = ST_ACKWORD;
              ctl.loadPtr = 1'b1;
            end else if (rxHi == DEV_ID) begin
              nxt = ST_ACKDEV;
              ctl.latchBlk = 1'b1;
            end else nxt = ST_WAIT;
          end
        end
        ST_ACKDEV: if (ev.sclFall) begin
          ctl.clrCnt = 1'b1;
          if (rwBit) begin
            nxt = ST_TX;
            ctl.loadTx = 1'b1;
          end else nxt = ST_RXWORD;
        end
        ST_ACKWORD: if (ev.sclFall) nxt = ST_WAIT;
        ST_TX: if (ev.sclFall) begin
          ctl.shiftTx = 1'b1;
          if (bitCnt == 4'd7) nxt = ST_MACK;
        end
        ST_MACK: if (ev.sclFall) begin
          if (mAck && !holdIn) begin
            nxt = ST_TX;
            ctl.loadTx = 1'b1;
            ctl.clrCnt = 1'b1;
          end else nxt = ST_WAIT;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      mAck  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_MACK && ev.sclRise) mAck <= ~ev.sdaLvl;
    end
  end

  assign ackPhase = (state == ST_ACKDEV) || (state == ST_ACKWORD);
  assign sdaOe    = ackPhase || (state == ST_TX && !txBit);

  AST_MATCH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKDEV && $past(state) != ST_ACKDEV) |-> $past(rxHi) == DEV_ID); // R2
  AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackPhase) |-> !$past(holdIn)); // R8
  AST_NEXT_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX && $past(state) == ST_MACK) |-> $past(mAck)); // R5
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) && !$past(ev.startEv || ev.stopEv) |-> !ev.sclLvl); // R10

endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
  parameter int         ADDR_W      = 11,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic holdIn,
  output logic sdaOe
);
  import i2c_rd_pkg::*;

  ctlT               ctl;
  busEvT             ev;
  logic [3:0]        rxHi, bitCnt;
  logic              rwBit, txBit;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        memQ;

  i2c_rd_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .memQ(memQ), .ev(ev), .rxHi(rxHi), .rwBit(rwBit), .bitCnt(bitCnt),
    .txBit(txBit), .ptr(ptr)
  );

  i2c_rd_ctrl #(.DEV_ID(DEV_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .holdIn(holdIn), .ev(ev), .rxHi(rxHi),
    .rwBit(rwBit), .bitCnt(bitCnt), .txBit(txBit), .ctl(ctl), .sdaOe(sdaOe)
  );

  i2c_rd_mem #(.ADDR_W(ADDR_W)) uMem (
    .clk(clk), .addr(ptr), .q(memQ)
  );

endmodule

// File: tb/tb_i2c_rd_target.sv
module tb_i2c_rd_target;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, holdIn = 1'b0;
  logic sdaOe, sdaLine;
  logic busCond = 1'b0;
  logic prevOe = 1'b0;
  int   nChk = 0, nErr = 0;
  int   ptrM = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_rd_target dut (.clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
                     .holdIn(holdIn), .sdaOe(sdaOe));

  function automatic logic [7:0] memRef(input int a);
    logic [10:0] ad;
    ad = 11'(a);
    return ad[7:0] ^ {ad[10:8], 5'b10101};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10: every change of sdaOe must happen while the master holds SCL low
  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe) chk(!sclM || busCond, "R10 sdaOe moved with SCL high", sclM, 0);
    prevOe = sdaOe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    busCond = 1'b1;
    sdaM = 1'b1; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b0; tick(H);
    sclM = 1'b0; tick(H);
    busCond = 1'b0;
  endtask

  task automatic stopCond();
    busCond = 1'b1;
    sdaM = 1'b0; tick(H);
    sclM = 1'b1; tick(H);
    sdaM = 1'b1; tick(2 * H);
    busCond = 1'b0;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; tick(H);
      sclM = 1'b1; tick(H);
      sclM = 1'b0; tick(1);
    end
  endtask

  task automatic writeByte(input logic [7:0] b, output bit ack);
    bit a1, a2;
    sendBits(b, 8);
    sdaM = 1'b1; tick(H);
    sclM = 1'b1; tick(1);
    a1 = !sdaLine; tick(H - 2);
    a2 = !sdaLine; tick(1);
    sclM = 1'b0; tick(1);
    ack = a1 && a2;
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      sclM = 1'b1; tick(H / 2);
      b[i] = sdaLine; tick(H / 2);
      sclM = 1'b0; tick(1);
    end
    sdaM = !giveAck; tick(H);
    sclM = 1'b1; tick(H);
    sclM = 1'b0; tick(1);
    sdaM = 1'b1;
  endtask

  task automatic expAck(input logic [7:0] b, input bit exp, input string req);
    bit a;
    writeByte(b, a);
    chk(a == exp, req, a, exp);
  endtask

  task automatic expRead(input bit giveAck, input int exp, input string req);
    logic [7:0] d;
    readByte(giveAck, d);
    chk(d == exp[7:0], req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  end

  initial begin
    tick(5);
    rstN = 1'b1;
    tick(3);
    chk(sdaOe == 1'b0, "R1 sdaOe after reset", sdaOe, 0);

    // R1/R7: current-address read right after reset starts at 0
    startCond();
    expAck(8'hA1, 1'b1, "R2 read target byte ack");
    expRead(1'b0, memRef(0), "R1 first byte at pointer 0");
    ptrM = 1;
    stopCond();

    // R3/R4: random read at 0x123
    startCond();
    expAck(8'hA2, 1'b1, "R3 write target byte ack");
    expAck(8'h23, 1'b1, "R3 word byte ack");
    startCond();
    expAck(8'hA3, 1'b1, "R4 read target ack");
    expRead(1'b0, memRef(12'h123), "R4 random read data");
    tick(4);
    chk(sdaOe == 1'b0, "R6 released after NACK", sdaOe, 0);
    expRead(1'b0, 8'hFF, "R6 silent until STOP");
    ptrM = 12'h124;
    stopCond();

    // R5: sequential read across the top of the array
    startCond();
    expAck(8'hAE, 1'b1, "R3 target byte blk7");
    expAck(8'hFE, 1'b1, "R3 word FE");
    startCond();
    expAck(8'hAF, 1'b1, "R4 read target");
    expRead(1'b1, memRef(12'h7FE), "R5 byte 7FE");
    expRead(1'b1, memRef(12'h7FF), "R5 byte 7FF");
    expRead(1'b1, memRef(0), "R5 wrap to 000");
    expRead(1'b0, memRef(1), "R5 byte 001");
    ptrM = 2;
    stopCond();

    // R7: current-address read continues from pointer
    startCond();
    expAck(8'hA5, 1'b1, "R7 current read target");
    expRead(1'b1, memRef(ptrM), "R7 current byte");
    expRead(1'b0, memRef(ptrM + 1), "R7 next byte");
    ptrM += 2;
    stopCond();

    // R2: wrong target id is ignored
    startCond();
    expAck(8'hB1, 1'b0, "R2 mismatched id no ack");
    expRead(1'b0, 8'hFF, "R2 mismatched id bus ignored");
    stopCond();

    // R8: hold blocks acknowledges
    holdIn = 1'b1;
    startCond();
    expAck(8'hA0, 1'b0, "R8 target byte under hold");
    stopCond();
    holdIn = 1'b0;
    startCond();
    expAck(8'hA4, 1'b1, "R8 target byte without hold");
    holdIn = 1'b1;
    expAck(8'h55, 1'b0, "R8 word byte under hold");
    holdIn = 1'b0;
    stopCond();
    startCond();
    expAck(8'hA1, 1'b1, "R8 read target without hold");
    holdIn = 1'b1;
    expRead(1'b1, memRef(ptrM), "R8 byte sent before hold ack");
    expRead(1'b0, 8'hFF, "R8 ack under hold ends read");
    holdIn = 1'b0;
    ptrM += 1;
    stopCond();

    // R9: START inside word byte keeps pointer
    startCond();
    expAck(8'hA6, 1'b1, "R9 target byte");
    sendBits(8'h3C, 3);
    startCond();
    expAck(8'hA1, 1'b1, "R9 restart after mid-byte START");
    expRead(1'b0, memRef(ptrM), "R9 pointer unchanged");
    ptrM += 1;
    stopCond();

    // R9: STOP inside target byte returns to idle
    startCond();
    sendBits(8'hA1, 4);
    stopCond();
    startCond();
    expAck(8'hA1, 1'b1, "R9 ack after mid-byte STOP");
    expRead(1'b0, memRef(ptrM), "R9 data after abort");
    ptrM += 1;
    stopCond();

    // R5/R7: pointer wrap seen by a current-address read
    startCond();
    expAck(8'hAE, 1'b1, "R3 target byte");
    expAck(8'hFF, 1'b1, "R3 word FF");
    startCond();
    expAck(8'hAF, 1'b1, "R4 read target");
    expRead(1'b0, memRef(12'h7FF), "R4 byte 7FF");
    stopCond();
    startCond();
    expAck(8'hA1, 1'b1, "R7 current read target");
    expRead(1'b0, memRef(0), "R5 pointer wrapped to 0");
    stopCond();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

endmodule